// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a 10-bit successive-approximation converter with eight multiplexed analog inputs. All logic runs on the system clock. A programmable divider makes a one-cycle enable pulse every 4, 8, 16 or 32 system cycles, and each enable marks one conversion-clock period. A conversion has a sampling window of four periods. Ten approximation periods follow it, and each one resolves one result bit, working from the most significant bit down. The comparator is a single-bit input. It is 1 when the selected input is at or above the trial code that the block presents on `dac_code`.

A conversion can be started by a software start pulse or by an internal trigger pulse. When a conversion ends, the result register is loaded and a sticky interrupt flag is set. The flag stays set until it is cleared with a write-one-to-clear input. In single mode the sequencer returns to idle after one result. In continuous mode it immediately starts the next conversion, using the channel and divider setting present at that moment.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A conversion decides the 10 result bits one per conversion-clock period, from bit 9 down to bit 0. Each trial code is the bits already kept plus the bit under test. The bit is kept when `cmp_in` is 1 at the enable that ends its period. Against an ideal comparator, the loaded result equals the input value (0 to 1023).
- R2: `mux_sel` shows the channel captured from `chan_sel` at conversion start. It does not change while that conversion runs.
- R3: `div_sel` selects the conversion-clock period: 00 = 4, 01 = 8, 10 = 16, 11 = 32 system cycles. A whole conversion lasts 14 periods (4 sampling and 10 approximation), so `busy` stays high for 14 times the period.
- R4: Changes to `div_sel` or `chan_sel` made during a conversion have no effect on that conversion.
- R5: In single mode (`cont_mode` = 0) the block goes idle after one conversion and stays idle without a new start.
- R6: In continuous mode the next conversion begins in the same cycle that the previous result is loaded, with no idle cycle in between.
- R7: A pulse on `trig_in` starts a conversion in the same way as a pulse on `sw_start`.
- R8: `irq` rises in the cycle the result is loaded. It then stays high until a cycle with `irq_clr` = 1, and a completing conversion wins over a clear in the same cycle.
- R9: `busy` rises on the clock edge that accepts a start and falls on the edge that loads the result. A start request while `busy` is high is ignored.
- R10: If `cont_mode` is cleared during a continuous run, the running conversion still completes, and the block then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software start request |
| trig_in | input | 1 | Internal trigger start request |
| cont_mode | input | 1 | 1 = continuous, 0 = single |
| div_sel | input | 2 | Conversion-clock divider select |
| chan_sel | input | 3 | Channel to convert |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| irq_clr | input | 1 | Clears the interrupt flag when 1 |
| busy | output | 1 | Conversion in progress |
| mux_sel | output | 3 | Channel driven to the input multiplexer |
| dac_code | output | 10 | Trial code (0 while sampling or idle) |
| result | output | 10 | Last completed conversion result |
| irq | output | 1 | Sticky end-of-conversion flag |

## Verification
The bench runs an independent cycle-by-cycle model and compares the trial code on `dac_code` with it on every clock. A wrong bit index, a wrong kept/dropped decision or a miscounted divider therefore shows up as a mismatch within one conversion-clock period. It surfaces no later than 32 system cycles after the fault. A wrongly relatched channel or a missed stop shows up on `mux_sel` or `busy` in the very next cycle. An error in the final accumulation appears as a `result` that differs from the bench's analog value at the edge where `irq` rises.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int RATIO_W    = 2,
    parameter int BASE_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam int MAX_DIV = 1 << (BASE_SHIFT + (1 << RATIO_W) - 1);
    localparam int CNT_W   = $clog2(MAX_DIV);

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [CNT_W-1:0]   cnt;
    } div_regs_t;

    div_regs_t q, d;
    logic [CNT_W:0]   one_hot;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        one_hot  = (CNT_W+1)'(1) << (BASE_SHIFT + int'(q.ratio));
        last_cnt = CNT_W'(one_hot - (CNT_W+1)'(1));
        tick     = run && (q.cnt == last_cnt);
        d        = q;
        if (restart) begin
            d.ratio = ratio;
            d.cnt   = '0;
        end else if (run) begin
            d.cnt = tick ? '0 : q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: an enable is always a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int RES_W        = 10,
    parameter int CH_W         = 3,
    parameter int SAMPLE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             cont_mode,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             tick,
    input  logic             cmp_in,
    input  logic             irq_clr,
    output logic             busy,
    output logic             restart,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    localparam int BIT_W  = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam int SAMP_W = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;

    typedef struct packed {
        sar_state_e        st;
        logic [SAMP_W-1:0] samp;
        logic [BIT_W-1:0]  bitn;
        logic [RES_W-1:0]  acc;
        logic [CH_W-1:0]   chan;
        logic [RES_W-1:0]  result;
        logic              irq;
    } eng_regs_t;

    eng_regs_t q, d;
    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] acc_next;
    logic             fin;

    always_comb begin
        mask     = RES_W'(1) << q.bitn;
        acc_next = cmp_in ? (q.acc | mask) : q.acc;
        d        = q;
        restart  = 1'b0;
        fin      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req) begin
                    d.st    = ST_SAMPLE;
                    d.samp  = '0;
                    d.chan  = chan_sel;
                    restart = 1'b1;
                end
            end
            ST_SAMPLE: begin
                if (tick) begin
                    if (q.samp == SAMP_W'(SAMPLE_TICKS - 1)) begin
                        d.st   = ST_CONV;
                        d.bitn = BIT_W'(RES_W - 1);
                        d.acc  = '0;
                    end else begin
                        d.samp = q.samp + SAMP_W'(1);
                    end
                end
            end
            ST_CONV: begin
                if (tick) begin
                    d.acc = acc_next;
                    if (q.bitn == '0) begin
                        fin      = 1'b1;
                        d.result = acc_next;
                        if (cont_mode) begin
                            d.st    = ST_SAMPLE;
                            d.samp  = '0;
                            d.chan  = chan_sel;
                            restart = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.bitn = q.bitn - BIT_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (fin)          d.irq = 1'b1;
        else if (irq_clr) d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign busy     = (q.st != ST_IDLE);
    assign mux_sel  = q.chan;
    assign dac_code = (q.st == ST_CONV) ? (q.acc | mask) : '0;
    assign result   = q.result;
    assign irq      = q.irq;

    // R1: result register changes only at completion, which sets the flag
    a_r1_result_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.result) |-> q.irq);
    // R2 / R9: channel held while converting, start requests ignored
    a_r2_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(q.chan));
    // R8: flag sticks until cleared
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && !irq_clr) |=> q.irq);
    // R5: single mode stops after the last bit
    a_r5_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !cont_mode) |=> !busy);
    // R6: continuous mode restarts without an idle cycle
    a_r6_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && cont_mode) |=> busy);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int RES_W        = 10,
    parameter int CH_W         = 3,
    parameter int RATIO_W      = 2,
    parameter int BASE_SHIFT   = 2,
    parameter int SAMPLE_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_start,
    input  logic               trig_in,
    input  logic               cont_mode,
    input  logic [RATIO_W-1:0] div_sel,
    input  logic [CH_W-1:0]    chan_sel,
    input  logic               cmp_in,
    input  logic               irq_clr,
    output logic               busy,
    output logic [CH_W-1:0]    mux_sel,
    output logic [RES_W-1:0]   dac_code,
    output logic [RES_W-1:0]   result,
    output logic               irq
);
    logic req;
    logic tick;
    logic restart;

    assign req = sw_start | trig_in;

    sar_clkdiv #(
        .RATIO_W    (RATIO_W),
        .BASE_SHIFT (BASE_SHIFT)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (restart),
        .ratio   (div_sel),
        .tick    (tick)
    );

    sar_engine #(
        .RES_W        (RES_W),
        .CH_W         (CH_W),
        .SAMPLE_TICKS (SAMPLE_TICKS)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .cont_mode (cont_mode),
        .chan_sel  (chan_sel),
        .tick      (tick),
        .cmp_in    (cmp_in),
        .irq_clr   (irq_clr),
        .busy      (busy),
        .restart   (restart),
        .mux_sel   (mux_sel),
        .dac_code  (dac_code),
        .result    (result),
        .irq       (irq)
    );

    // R9 / R7: an idle block accepts either start source on the next edge
    a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (sw_start || trig_in)) |=> busy);
endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_start = 1'b0;
    logic       trig_in = 1'b0;
    logic       cont_mode = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic [2:0] chan_sel = 3'd0;
    logic       cmp_in;
    logic       irq_clr = 1'b0;
    logic       busy;
    logic [2:0] mux_sel;
    logic [9:0] dac_code;
    logic [9:0] result;
    logic       irq;

    int vin [8];
    int total = 0;
    int bad = 0;
    int cycles = 0;

    int m_busy = 0, m_div = 4, m_sub = 0, m_tick = 0, m_acc = 0;
    int m_chan = 0, m_res = 0, m_irq = 0;
    int run_len = 0, last_len = 0, done_cnt = 0;

    always #4 clk = ~clk;

    assign cmp_in = (vin[mux_sel] >= int'(dac_code));

    sar_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .trig_in(trig_in),
        .cont_mode(cont_mode), .div_sel(div_sel), .chan_sel(chan_sel),
        .cmp_in(cmp_in), .irq_clr(irq_clr), .busy(busy), .mux_sel(mux_sel),
        .dac_code(dac_code), .result(result), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // behavioural reference: conversion = 4 sample ticks + 10 bit ticks
    always @(posedge clk) begin
        int done;
        int b;
        done = 0;
        if (!rst_n) begin
            m_busy = 0; m_sub = 0; m_tick = 0; m_acc = 0;
            m_chan = 0; m_res = 0; m_irq = 0;
        end else begin
            if (m_busy != 0) begin
                if (m_sub == m_div - 1) begin
                    m_sub = 0;
                    if (m_tick >= 4) begin
                        b = 13 - m_tick;
                        if (vin[m_chan] >= (m_acc | (1 << b))) m_acc = m_acc | (1 << b);
                    end
                    if (m_tick == 13) begin
                        done = 1;
                        m_res = m_acc;
                        if (cont_mode) begin
                            m_chan = int'(chan_sel); m_div = 4 << div_sel;
                            m_tick = 0; m_acc = 0;
                        end else m_busy = 0;
                    end else m_tick++;
                end else m_sub++;
            end else if (sw_start || trig_in) begin
                m_busy = 1; m_chan = int'(chan_sel); m_div = 4 << div_sel;
                m_sub = 0; m_tick = 0; m_acc = 0;
            end
            if (done != 0) begin
                m_irq = 1;
                done_cnt++;
            end else if (irq_clr) m_irq = 0;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        int m_dac;
        cycles++;
        if (rst_n) begin
            m_dac = (m_busy != 0 && m_tick >= 4) ? (m_acc | (1 << (13 - m_tick))) : 0;
            chk("R9 busy", int'(busy), m_busy);
            chk("R2 mux_sel", int'(mux_sel), m_chan);
            chk("R1 dac_code", int'(dac_code), m_dac);
            chk("R1 result", int'(result), m_res);
            chk("R8 irq", int'(irq), m_irq);
            if (busy) run_len++;
            else if (run_len != 0) begin
                last_len = run_len;
                run_len = 0;
            end
        end
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse_start(input bit use_trig);
        @(negedge clk);
        if (use_trig) trig_in = 1'b1; else sw_start = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; sw_start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic one_conv(input int ch, input int val, input int ratio, input bit use_trig);
        vin[ch] = val; chan_sel = 3'(ch); div_sel = 2'(ratio);
        pulse_start(use_trig);
        wait_idle();
        chk("R1 result equals input", int'(result), val);
        chk("R3 busy length", last_len, 14 * (4 << ratio));
        chk("R8 irq set at end", int'(irq), 1);
        clear_irq();
        @(negedge clk);
        chk("R8 irq cleared", int'(irq), 0);
    endtask

    initial begin
        int dc;
        for (int i = 0; i < 8; i++) vin[i] = 37 * i + 5;
        repeat (3) @(negedge clk);
        chk("R9 reset busy", int'(busy), 0);
        chk("R8 reset irq", int'(irq), 0);
        chk("R1 reset result", int'(result), 0);
        rst_n = 1'b1;

        one_conv(3, 677, 0, 0);
        one_conv(0, 0, 1, 0);
        one_conv(7, 1023, 2, 0);
        one_conv(5, 512, 3, 0);
        one_conv(2, 511, 0, 0);
        // R7: internal trigger start
        one_conv(6, 341, 1, 1);

        // R9 / R4: start while busy ignored, mid-run setting changes ignored
        vin[1] = 300; vin[4] = 800;
        chan_sel = 3'd1; div_sel = 2'd0;
        pulse_start(0);
        repeat (20) @(negedge clk);
        chan_sel = 3'd4; div_sel = 2'd3;
        pulse_start(1);
        repeat (5) @(negedge clk);
        chk("R4 mux_sel kept", int'(mux_sel), 1);
        wait_idle();
        chk("R9 ignored start result", int'(result), 300);
        chk("R4 period unchanged", last_len, 56);
        // R5: no restart without a new start
        repeat (30) @(negedge clk);
        chk("R5 stays idle", int'(busy), 0);
        clear_irq();

        // R6 / R10: continuous run, then stop
        vin[2] = 123; chan_sel = 3'd2; div_sel = 2'd0; cont_mode = 1'b1;
        dc = done_cnt;
        pulse_start(0);
        while (done_cnt < dc + 2) @(negedge clk);
        chk("R6 still busy after result", int'(busy), 1);
        chk("R6 result", int'(result), 123);
        repeat (10) @(negedge clk);
        cont_mode = 1'b0;
        while (busy) @(negedge clk);
        chk("R10 third conversion completed", done_cnt, dc + 3);
        repeat (40) @(negedge clk);
        chk("R10 idle after stop", int'(busy), 0);
        chk("R8 irq held without clear", int'(irq), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule